// File: doc/BRIEF.md
# Coprocessor Escape Instruction Snooper

This block sits beside a host processor and watches, without driving anything, the stream of instruction bytes the host executes. A two-byte instruction whose first byte carries the escape tag belongs to the coprocessor. The block decodes that instruction into a six-bit opcode, a two-bit mode and a three-bit register/memory selector. When the mode names a memory operand, the block does not fetch anything itself at first. The host runs a single dummy word read at the operand's effective address, and the block snoops that cycle. From it the block keeps the address and, for read-type opcodes, the data word.

If more operand words are needed, the block raises a bus request. It moves the remaining words itself, but only in cycles where it holds the grant, at addresses that step by two per word. It drops the request in the cycle right after the last word. Write-type opcodes ignore the data word the host returns: the whole operand is written from the execution side, one word per granted cycle. Register-mode instructions and unsupported opcodes never touch the bus. The execution side receives a one-cycle completion pulse together with the decoded fields and the gathered operand.

Top module: `esc_snooper`

## Requirements
- R1: A byte is claimed as the start of a coprocessor instruction only when its bits 7..3 equal 5'b11011. Any other byte, and any host bus cycle seen while idle, produces no request, no completion pulse and no error.
- R2: The reported opcode is {first byte bits 2..0, second byte bits 5..3}. The mode is second-byte bits 7..6 and the register/memory selector is second-byte bits 2..0.
- R3: Mode 2'b11 is a register operand. The completion pulse (op_valid) appears in the cycle after the second byte is accepted, with op_mem low, op_words equal to the looked-up length, an all-zero operand, and no bus request at any time.
- R4: Opcode bits 5..4 set the operand length in 16-bit words (00:1, 01:2, 10:4, 11:5). Opcode bit 3 selects the direction (1: write to memory, 0: read from memory).
- R5: For a memory read operand, the host cycle's data becomes operand word 0 (bits 15..0), and its address is reported on op_addr. Word k (k>=1) is read by the block at host address + 2k, and lands in operand bits 16k+15..16k.
- R6: For a memory write operand, the host cycle's data is discarded and the reported operand is all zero. Words 0..n-1 are written at host address + 2k with lb_wr high, and each word's data is taken from ex_wdata while ex_word_idx equals k.
- R7: The bus request drops, and op_valid pulses, in the cycle immediately after the last block-driven transfer. A one-word read completes in the cycle after the host cycle and never requests the bus.
- R8: A transfer takes place only in a cycle where both bus_grant and bus_req are high (lb_drive high). If the grant is withdrawn partway through, the request stays high and the transfers resume at the next address. Addresses wrap modulo 2^AW.
- R9: If ex_unsup is high while the second byte is accepted, the instruction is dropped: no request, no op_valid, and err_flag goes high and stays high until reset.
- R10: After reset, bus_req, lb_drive, lb_wr, op_valid and err_flag are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ib_valid | input | 1 | Executed instruction byte strobe |
| ib_byte | input | 8 | Executed instruction byte |
| hb_cycle | input | 1 | Host operand read cycle completes this clock |
| hb_addr | input | AW | Host cycle address |
| hb_data | input | DW | Host cycle data word |
| bus_grant | input | 1 | Bus grant from host |
| bus_req | output | 1 | Bus request to host |
| lb_drive | output | 1 | Block drives the bus this cycle |
| lb_wr | output | 1 | Driven cycle is a write |
| lb_addr | output | AW | Driven address |
| lb_wdata | output | DW | Driven write data |
| lb_rdata | input | DW | Read data for a driven read |
| ex_unsup | input | 1 | Execution side marks op_probe unsupported |
| ex_word_idx | output | CW | Index of the operand word being written |
| ex_wdata | input | DW | Write data for word ex_word_idx |
| op_probe | output | 6 | Opcode formed from the held first byte and the current byte |
| op_valid | output | 1 | One-cycle completion pulse |
| op_code | output | 6 | Decoded opcode |
| op_mode | output | 2 | Mode field |
| op_rm | output | 3 | Register/memory field |
| op_mem | output | 1 | Operand is in memory |
| op_words | output | CW | Operand length in words |
| op_addr | output | AW | Captured operand address |
| op_operand | output | MAXW*DW | Gathered operand, word k at bits 16k+15..16k |
| err_flag | output | 1 | Sticky unsupported-opcode flag |

## Verification
The hardest case to reach from the ports is a grant withdrawn in the middle of a multi-word transfer, followed by wrap of the address counter. The bench's grant model can hold the grant low for two cycles right after the first block-driven word. One write vector also starts its operand four bytes below the top of the address space, so the same operation both pauses and wraps. Here the bench checks that the request stays up, that no word is skipped or repeated, and that release still comes one cycle after the final word.

// File: rtl/esc_pkg.sv
package esc_pkg;

    localparam int ESC_MAXW = 5;
    localparam int ESC_CW   = $clog2(ESC_MAXW + 1);
    localparam logic [4:0] ESC_TAG = 5'b11011;
    localparam logic [1:0] MODE_REG = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BYTE2,
        ST_HOST,
        ST_BUS
    } esc_st_e;

    // operand length in words chosen by opcode bits 5..4
    function automatic logic [ESC_CW-1:0] esc_len(input logic [1:0] sel);
        case (sel)
            2'b00:   return ESC_CW'(1);
            2'b01:   return ESC_CW'(2);
            2'b10:   return ESC_CW'(4);
            default: return ESC_CW'(5);
        endcase
    endfunction

endpackage

// File: rtl/esc_decode.sv
module esc_decode
    import esc_pkg::*;
#(
    parameter int CW = ESC_CW
) (
    input  logic [2:0]    lead_low,
    input  logic [7:0]    modrm,
    output logic [5:0]    dec_op,
    output logic [1:0]    dec_mode,
    output logic [2:0]    dec_rm,
    output logic          dec_mem,
    output logic          dec_wr,
    output logic [CW-1:0] dec_words
);
    always_comb begin
        dec_op    = {lead_low, modrm[5:3]};
        dec_mode  = modrm[7:6];
        dec_rm    = modrm[2:0];
        dec_mem   = (modrm[7:6] != MODE_REG);
        dec_wr    = dec_op[3];
        dec_words = CW'(esc_len(dec_op[5:4]));
    end
endmodule

// File: rtl/esc_opbuf.sv
module esc_opbuf #(
    parameter int DW   = 16,
    parameter int MAXW = 5,
    localparam int CW  = $clog2(MAXW + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [CW-1:0]      idx,
    input  logic [DW-1:0]      wdata,
    output logic [MAXW*DW-1:0] words
);
    logic [DW-1:0] word_d [MAXW];
    logic [DW-1:0] word_q [MAXW];

    for (genvar g = 0; g < MAXW; g++) begin : g_word
        always_comb begin
            word_d[g] = word_q[g];
            if (clr) begin
                word_d[g] = '0;
            end else if (we && (idx == CW'(g))) begin
                word_d[g] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d[g];
            end
        end

        assign words[g*DW +: DW] = word_q[g];
    end
endmodule

// File: rtl/esc_seq.sv
module esc_seq
    import esc_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int MAXW = ESC_MAXW,
    localparam int CW  = $clog2(MAXW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ib_valid,
    input  logic [7:0]    ib_byte,
    input  logic          hb_cycle,
    input  logic [AW-1:0] hb_addr,
    input  logic [DW-1:0] hb_data,
    input  logic          bus_grant,
    input  logic [DW-1:0] lb_rdata,
    input  logic          ex_unsup,
    input  logic [DW-1:0] ex_wdata,
    // decoder
    output logic [2:0]    lead_low,
    input  logic [5:0]    dec_op,
    input  logic [1:0]    dec_mode,
    input  logic [2:0]    dec_rm,
    input  logic          dec_mem,
    input  logic          dec_wr,
    input  logic [CW-1:0] dec_words,
    // operand buffer
    output logic          buf_clr,
    output logic          buf_we,
    output logic [CW-1:0] buf_idx,
    output logic [DW-1:0] buf_wdata,
    // bus side
    output logic          bus_req,
    output logic          lb_drive,
    output logic          lb_wr,
    output logic [AW-1:0] lb_addr,
    output logic [DW-1:0] lb_wdata,
    output logic [CW-1:0] ex_word_idx,
    // results
    output logic          op_valid,
    output logic [5:0]    op_code,
    output logic [1:0]    op_mode,
    output logic [2:0]    op_rm,
    output logic          op_mem,
    output logic [CW-1:0] op_words,
    output logic [AW-1:0] op_addr,
    output logic          err_flag
);
    typedef struct packed {
        esc_st_e       st;
        logic [2:0]    lead;
        logic [5:0]    op;
        logic [1:0]    mode;
        logic [2:0]    rm;
        logic          wr;
        logic [CW-1:0] words;
        logic [CW-1:0] cnt;
        logic [AW-1:0] base;
        logic          done;
        logic          err;
    } seq_s;

    seq_s s_d, s_q;
    logic          last_word;
    logic [AW-1:0] cur_addr;

    assign last_word = (s_q.cnt == (s_q.words - CW'(1)));
    assign cur_addr  = s_q.base + AW'({s_q.cnt, 1'b0});

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        buf_clr   = 1'b0;
        buf_we    = 1'b0;
        buf_idx   = s_q.cnt;
        buf_wdata = lb_rdata;
        bus_req   = 1'b0;
        lb_drive  = 1'b0;
        lb_wr     = 1'b0;
        lb_wdata  = '0;

        case (s_q.st)
            ST_IDLE: begin
                if (ib_valid && (ib_byte[7:3] == ESC_TAG)) begin
                    s_d.lead = ib_byte[2:0];
                    s_d.st   = ST_BYTE2;
                end
            end
            ST_BYTE2: begin
                if (ib_valid) begin
                    s_d.op    = dec_op;
                    s_d.mode  = dec_mode;
                    s_d.rm    = dec_rm;
                    s_d.wr    = dec_wr;
                    s_d.words = dec_words;
                    s_d.cnt   = '0;
                    buf_clr   = 1'b1;
                    if (ex_unsup) begin
                        s_d.err = 1'b1;
                        s_d.st  = ST_IDLE;
                    end else if (!dec_mem) begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.st = ST_HOST;
                    end
                end
            end
            ST_HOST: begin
                if (hb_cycle) begin
                    s_d.base = hb_addr;
                    if (s_q.wr) begin
                        s_d.cnt = '0;
                        s_d.st  = ST_BUS;
                    end else begin
                        buf_we    = 1'b1;
                        buf_idx   = '0;
                        buf_wdata = hb_data;
                        s_d.cnt   = CW'(1);
                        if (s_q.words == CW'(1)) begin
                            s_d.done = 1'b1;
                            s_d.st   = ST_IDLE;
                        end else begin
                            s_d.st = ST_BUS;
                        end
                    end
                end
            end
            ST_BUS: begin
                bus_req = 1'b1;
                if (bus_grant) begin
                    lb_drive = 1'b1;
                    lb_wr    = s_q.wr;
                    if (s_q.wr) begin
                        lb_wdata = ex_wdata;
                    end else begin
                        buf_we = 1'b1;
                    end
                    s_d.cnt = s_q.cnt + CW'(1);
                    if (last_word) begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign lead_low    = s_q.lead;
    assign lb_addr     = cur_addr;
    assign ex_word_idx = s_q.cnt;
    assign op_valid    = s_q.done;
    assign op_code     = s_q.op;
    assign op_mode     = s_q.mode;
    assign op_rm       = s_q.rm;
    assign op_mem      = (s_q.mode != MODE_REG);
    assign op_words    = s_q.words;
    assign op_addr     = s_q.base;
    assign err_flag    = s_q.err;
endmodule

// File: rtl/esc_snooper.sv
module esc_snooper
    import esc_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int MAXW = ESC_MAXW,
    localparam int CW  = $clog2(MAXW + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ib_valid,
    input  logic [7:0]         ib_byte,
    input  logic               hb_cycle,
    input  logic [AW-1:0]      hb_addr,
    input  logic [DW-1:0]      hb_data,
    input  logic               bus_grant,
    output logic               bus_req,
    output logic               lb_drive,
    output logic               lb_wr,
    output logic [AW-1:0]      lb_addr,
    output logic [DW-1:0]      lb_wdata,
    input  logic [DW-1:0]      lb_rdata,
    input  logic               ex_unsup,
    output logic [CW-1:0]      ex_word_idx,
    input  logic [DW-1:0]      ex_wdata,
    output logic [5:0]         op_probe,
    output logic               op_valid,
    output logic [5:0]         op_code,
    output logic [1:0]         op_mode,
    output logic [2:0]         op_rm,
    output logic               op_mem,
    output logic [CW-1:0]      op_words,
    output logic [AW-1:0]      op_addr,
    output logic [MAXW*DW-1:0] op_operand,
    output logic               err_flag
);
    logic [2:0]    lead_low;
    logic [5:0]    dec_op;
    logic [1:0]    dec_mode;
    logic [2:0]    dec_rm;
    logic          dec_mem;
    logic          dec_wr;
    logic [CW-1:0] dec_words;
    logic          buf_clr;
    logic          buf_we;
    logic [CW-1:0] buf_idx;
    logic [DW-1:0] buf_wdata;

    esc_decode #(.CW(CW)) u_dec (
        .lead_low  (lead_low),
        .modrm     (ib_byte),
        .dec_op    (dec_op),
        .dec_mode  (dec_mode),
        .dec_rm    (dec_rm),
        .dec_mem   (dec_mem),
        .dec_wr    (dec_wr),
        .dec_words (dec_words)
    );

    esc_seq #(.AW(AW), .DW(DW), .MAXW(MAXW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ib_valid    (ib_valid),
        .ib_byte     (ib_byte),
        .hb_cycle    (hb_cycle),
        .hb_addr     (hb_addr),
        .hb_data     (hb_data),
        .bus_grant   (bus_grant),
        .lb_rdata    (lb_rdata),
        .ex_unsup    (ex_unsup),
        .ex_wdata    (ex_wdata),
        .lead_low    (lead_low),
        .dec_op      (dec_op),
        .dec_mode    (dec_mode),
        .dec_rm      (dec_rm),
        .dec_mem     (dec_mem),
        .dec_wr      (dec_wr),
        .dec_words   (dec_words),
        .buf_clr     (buf_clr),
        .buf_we      (buf_we),
        .buf_idx     (buf_idx),
        .buf_wdata   (buf_wdata),
        .bus_req     (bus_req),
        .lb_drive    (lb_drive),
        .lb_wr       (lb_wr),
        .lb_addr     (lb_addr),
        .lb_wdata    (lb_wdata),
        .ex_word_idx (ex_word_idx),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .op_mode     (op_mode),
        .op_rm       (op_rm),
        .op_mem      (op_mem),
        .op_words    (op_words),
        .op_addr     (op_addr),
        .err_flag    (err_flag)
    );

    esc_opbuf #(.DW(DW), .MAXW(MAXW)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (buf_we),
        .idx   (buf_idx),
        .wdata (buf_wdata),
        .words (op_operand)
    );

    assign op_probe = dec_op;
endmodule

// File: rtl/esc_snooper_chk.sv
module esc_snooper_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_grant,
    input logic          bus_req,
    input logic          lb_drive,
    input logic          lb_wr,
    input logic [AW-1:0] lb_addr,
    input logic          op_valid,
    input logic          op_mem,
    input logic          err_flag
);
    // R8: the bus is driven only while both request and grant are high
    p_drive_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lb_drive |-> (bus_grant && bus_req));

    // R6: write strobe only on a driven cycle
    p_write_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr |-> lb_drive);

    // R7: completion comes with the request already released
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !bus_req);

    // R5: back-to-back driven cycles step the address by one word
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_drive && $past(lb_drive)) |-> (lb_addr == $past(lb_addr) + AW'(2)));

    // R9: error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flag) |-> err_flag);

    // R9: a dropped instruction neither requests nor completes
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (!bus_req && !op_valid));

    // R3: a register-mode completion had no request the cycle before
    p_reg_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_mem) |-> !$past(bus_req));
endmodule

bind esc_snooper esc_snooper_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_esc_snooper.sv
`timescale 1ns/1ps
module sim_esc_snooper;
    localparam int AW   = 20;
    localparam int DW   = 16;
    localparam int MAXW = 5;
    localparam int CW   = $clog2(MAXW + 1);
    localparam int NV   = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ib_valid = 1'b0;
    logic [7:0]         ib_byte = '0;
    logic               hb_cycle = 1'b0;
    logic [AW-1:0]      hb_addr = '0;
    logic [DW-1:0]      hb_data = '0;
    logic               bus_grant = 1'b0;
    logic               bus_req, lb_drive, lb_wr;
    logic [AW-1:0]      lb_addr;
    logic [DW-1:0]      lb_wdata, lb_rdata, ex_wdata;
    logic               ex_unsup;
    logic [CW-1:0]      ex_word_idx;
    logic [5:0]         op_probe, op_code;
    logic               op_valid, op_mem, err_flag;
    logic [1:0]         op_mode;
    logic [2:0]         op_rm;
    logic [CW-1:0]      op_words;
    logic [AW-1:0]      op_addr;
    logic [MAXW*DW-1:0] op_operand;

    logic       unsup_en = 1'b0;
    logic [5:0] unsup_code = '0;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    assign lb_rdata = memf(lb_addr);
    assign ex_wdata = 16'hC000 | DW'(ex_word_idx);
    assign ex_unsup = unsup_en && (op_probe == unsup_code);

    esc_snooper u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] s);
        case (s) 2'b00: return 1; 2'b01: return 2; 2'b10: return 4; default: return 5; endcase
    endfunction

    // fields: lead byte, second byte, host data, host address, grant latency, pause
    localparam logic [56:0] VECS [NV] = '{
        {8'hD8, 8'h06, 16'h1234, 20'h01000, 4'd0, 1'b0},
        {8'hDA, 8'h47, 16'hBEEF, 20'h02000, 4'd0, 1'b0},
        {8'hDC, 8'h85, 16'h0F0F, 20'h03010, 4'd3, 1'b0},
        {8'hDE, 8'h16, 16'h7777, 20'h04400, 4'd1, 1'b1},
        {8'hD9, 8'h1E, 16'hFFFF, 20'h05000, 4'd0, 1'b0},
        {8'hDD, 8'h5D, 16'hAAAA, 20'h06020, 4'd2, 1'b0},
        {8'hDF, 8'h2E, 16'h5555, 20'hFFFFC, 4'd1, 1'b1},
        {8'hD9, 8'hC1, 16'h0000, 20'h00000, 4'd0, 1'b0},
        {8'hD7, 8'h06, 16'h9999, 20'h07000, 4'd0, 1'b0},
        {8'h27, 8'h85, 16'h8888, 20'h08000, 4'd0, 1'b0}
    };

    task automatic run_vec(input logic [7:0] b1, input logic [7:0] b2, input logic [15:0] hd,
                           input logic [AW-1:0] addr, input int gl, input bit pause,
                           input bit exp_err);
        bit claim = (b1[7:3] == 5'b11011);
        logic [5:0] eop = {b1[2:0], b2[5:3]};
        bit emem = (b2[7:6] != 2'b11);
        int ew = len_of(eop[5:4]);
        bit ewr = eop[3];
        int nbus = !emem ? 0 : (ewr ? ew : ew - 1);
        int first = ewr ? 0 : 1;
        int xf = 0, gcnt = 0, hold = 0;
        bit seen = 0, rel = 0, req_seen = 0, abad = 0, dbad = 0;
        logic [79:0] got = '0, expv = '0;
        logic [5:0] g_op = '0;
        logic [1:0] g_mode = '0;
        logic [2:0] g_rm = '0;
        logic g_mem = 0;
        logic [CW-1:0] g_words = '0;
        logic [AW-1:0] g_addr = '0;

        ib_valid = 1'b1; ib_byte = b1;
        @(negedge clk); ib_byte = b2;
        @(negedge clk); ib_valid = 1'b0; ib_byte = '0;
        if (emem) begin
            hb_cycle = 1'b1; hb_addr = addr; hb_data = hd;
            @(negedge clk); hb_cycle = 1'b0; hb_data = '0;
        end
        for (int cyc = 0; cyc < 40 && !seen; cyc++) begin
            if (rel) begin
                chk(!bus_req && op_valid, "R7", "release after last word",
                    {bus_req, op_valid}, 80'h1);
                rel = 0;
            end
            if (bus_req) req_seen = 1;
            if (op_valid) begin
                seen = 1; got = op_operand; g_op = op_code; g_mode = op_mode;
                g_rm = op_rm; g_mem = op_mem; g_words = op_words; g_addr = op_addr;
            end else begin
                if (bus_req) gcnt++;
                bus_grant = bus_req && (gcnt > gl) && !(pause && xf == 1 && hold < 2);
                if (pause && xf == 1 && bus_req && hold < 2) hold++;
                #1;
                if (lb_drive) begin
                    if (lb_addr != AW'(addr + AW'(2 * (xf + first)))) abad = 1;
                    if (lb_wr != ewr) dbad = 1;
                    if (ewr && lb_wdata != (16'hC000 | 16'(xf))) dbad = 1;
                    xf++;
                    if (xf == nbus) rel = 1;
                end
                @(negedge clk);
            end
        end
        bus_grant = 1'b0;

        if (claim && !exp_err) begin
            if (emem && !ewr) begin
                expv[15:0] = hd;
                for (int k = 1; k < ew; k++) expv[16*k +: 16] = memf(AW'(addr + AW'(2 * k)));
            end
            chk(seen, "R1", "escape claimed", 80'(seen), 80'h1);
            chk(g_op == eop && g_mode == b2[7:6] && g_rm == b2[2:0], "R2", "decoded fields",
                {g_op, g_mode, g_rm}, {eop, b2[7:6], b2[2:0]});
            chk(g_words == CW'(ew), "R4", "operand length", 80'(g_words), 80'(ew));
            if (!emem) begin
                chk(!g_mem && !req_seen && got == 80'h0, "R3", "register operand",
                    {req_seen, g_mem, got[15:0]}, 80'h0);
            end else if (ewr) begin
                chk(got == 80'h0 && g_addr == addr, "R6", "write discards host word",
                    got, 80'h0);
                chk(xf == nbus && !abad && !dbad, "R6", "write transfers",
                    {abad, dbad, 16'(xf)}, 80'(nbus));
            end else begin
                chk(got == expv && g_addr == addr, "R5", "read operand", got, expv);
                chk(xf == nbus && !abad && !dbad, "R5", "read transfers",
                    {abad, dbad, 16'(xf)}, 80'(nbus));
                if (nbus == 0) chk(!req_seen, "R7", "one-word read no request",
                                   80'(req_seen), 80'h0);
            end
            if (pause) chk(!abad && xf == nbus, "R8", "grant pause resumes",
                           {abad, 16'(xf)}, 80'(nbus));
        end else if (exp_err) begin
            chk(!seen && !req_seen && err_flag, "R9", "unsupported dropped",
                {seen, req_seen, err_flag}, 80'h1);
        end else begin
            chk(!seen && !req_seen && !err_flag, "R1", "non-escape ignored",
                {seen, req_seen, err_flag}, 80'h0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req && !lb_drive && !lb_wr && !op_valid && !err_flag, "R10", "reset state",
            {bus_req, lb_drive, lb_wr, op_valid, err_flag}, 80'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_vec(VECS[v][56:49], VECS[v][48:41], VECS[v][40:25], VECS[v][24:5],
                    int'(VECS[v][4:1]), VECS[v][0], 1'b0);
        end

        // R9: opcode 6'b010000 marked unsupported
        unsup_en = 1'b1; unsup_code = 6'b010000;
        run_vec(8'hDA, 8'h47, 16'h1111, 20'h09000, 0, 1'b0, 1'b1);
        unsup_en = 1'b0;
        // R9: flag stays set across a later good instruction
        run_vec(8'hD8, 8'h06, 16'h2222, 20'h0A000, 0, 1'b0, 1'b0);
        chk(err_flag, "R9", "error flag sticky", 80'(err_flag), 80'h1);

        // R10: reset clears the flag
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!err_flag && !bus_req && !op_valid, "R10", "reset clears state",
            {err_flag, bus_req, op_valid}, 80'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule